// File: doc/BRIEF.md
# Write-Protect and Self-Timed Programming Controller

This block stands between the serial command slave of a small serial word memory and its storage array. The slave hands it decoded commands, one per frame: a read, a word write (address and 16-bit data), an arm command that permits writes, and a disarm command that forbids them. The block keeps the software write-permission latch. It also watches an external hold pin, which blocks writes in hardware. When a write is accepted, the block runs a self-timed programming interval whose length is a parameter in system clock cycles.

While programming is in progress, the block drives a busy flag back to the slave so that further frames are ignored. It also drives an active-low busy line (ready high) to the outside world, whether or not the chip is selected. When the interval ends, it commits the word with a single-cycle strobe to the array. Raising the hold pin during the interval stops programming on the next clock edge. In that case the target word is committed as all ones, as if erased but never programmed, and the block returns to ready at once.

Top module: `wpc_top`

## Requirements
- R1: After system reset the write-permission latch is clear, so a write frame received before any arm command produces no array strobe and leaves `ready_o` high.
- R2: An arm command (`cmd_op` = 2'b10) sets the latch, after which a write frame is accepted.
- R3: A disarm command (`cmd_op` = 2'b11) clears the latch, after which write frames are dropped without any strobe.
- R4: A read command (`cmd_op` = 2'b00) never changes the latch: writes keep succeeding after a read while armed, and keep failing after a read while disarmed.
- R5: A write frame (`cmd_op` = 2'b01) is dropped if `wr_hold` is high in any cycle while `frame_open` is high for that frame, including the cycle in which `cmd_valid` is high.
- R6: An accepted write raises `busy_o` and lowers `ready_o` from the clock edge that takes the frame's last cycle with `cmd_valid` high. Both stay in that state for exactly PROG_CYCLES cycles, independent of `frame_open`; at all other times `ready_o` is high.
- R7: At the end of an uninterrupted interval `arr_we` pulses for exactly one cycle, in the first cycle with `ready_o` high again, carrying the frame's address and data.
- R8: If `wr_hold` is high on a clock edge during the interval, that edge ends the interval and issues a one-cycle `arr_we` pulse with the target address and data of all ones.
- R9: `wr_hold` has no effect on arm, disarm or read commands.
- R10: While busy, every command (write, arm, disarm) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up reset |
| frame_open | input | 1 | High while the slave is shifting in a frame |
| cmd_valid | input | 1 | One-cycle pulse: decoded command ready, in the last cycle of the frame |
| cmd_op | input | 2 | Command code: 00 read, 01 write, 10 arm, 11 disarm |
| cmd_addr | input | ADDR_W | Word address of a write |
| cmd_data | input | DATA_W | Data word of a write |
| wr_hold | input | 1 | External hardware write-block / abort pin, active high |
| busy_o | output | 1 | Busy flag to the command slave |
| ready_o | output | 1 | Ready/busy line, low while programming |
| arr_we | output | 1 | One-cycle array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |

## Verification
The assertions check on every cycle the timing rules that hold locally. Each strobe lasts one cycle. A hold seen during programming ends it on the next edge and commits all ones. Arm and disarm set and clear the latch, and a read leaves it stable. Busy never starts from a cycle in which hold is high or the latch is clear. The scenarios alone can show the full interval length, the address and data of each committed word, and that a hold pulse earlier in a frame still kills that frame. They also show the end-to-end interplay: commands ignored during programming, and an arm command under hold that still enables a later write.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    typedef enum logic [1:0] {
        OP_READ   = 2'b00,
        OP_WRITE  = 2'b01,
        OP_ARM    = 2'b10,
        OP_DISARM = 2'b11
    } wpc_op_e;

    typedef struct packed {
        logic armed;
        logic hold_seen;
    } guard_st_t;

endpackage

// File: rtl/wpc_guard.sv
module wpc_guard
    import wpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_open,
    input  logic cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic wr_hold,
    input  logic busy,
    output logic armed,
    output logic write_ok
);

    guard_st_t st_d, st_q;
    wpc_op_e   op;

    always_comb begin
        op   = wpc_op_e'(cmd_op);
        st_d = st_q;
        // hardware hold is remembered for the whole open frame
        if (!frame_open) begin
            st_d.hold_seen = 1'b0;
        end else if (wr_hold) begin
            st_d.hold_seen = 1'b1;
        end
        if (cmd_valid && !busy) begin
            case (op)
                OP_ARM:    st_d.armed = 1'b1;
                OP_DISARM: st_d.armed = 1'b0;
                default:   st_d.armed = st_q.armed;
            endcase
        end
        write_ok = cmd_valid && !busy && (op == OP_WRITE) && st_q.armed
                   && !wr_hold && !st_q.hold_seen;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed = st_q.armed;

    assert_arm_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op == 2'b10) |=> armed);

    assert_disarm_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op == 2'b11) |=> !armed);

    assert_read_keeps_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'b00) |=> $stable(armed));

    assert_busy_freezes_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(armed));

endmodule

// File: rtl/wpc_timer.sv
module wpc_timer #(
    parameter int ADDR_W      = 9,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wr_hold,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [DATA_W-1:0] start_data,
    output logic              busy,
    output logic              strobe,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data
);

    localparam int CNT_W = (PROG_CYCLES > 2) ? $clog2(PROG_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PROG_CYCLES - 1);

    typedef struct packed {
        logic              busy;
        logic              strobe;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] wdata;
    } timer_st_t;

    timer_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        if (st_q.busy) begin
            if (wr_hold) begin
                // abort: cell left erased, never programmed
                st_d.busy   = 1'b0;
                st_d.strobe = 1'b1;
                st_d.wdata  = '1;
            end else if (st_q.cnt == '0) begin
                st_d.busy   = 1'b0;
                st_d.strobe = 1'b1;
                st_d.wdata  = st_q.data;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CNT_LOAD;
            st_d.addr = start_addr;
            st_d.data = start_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = st_q.busy;
    assign strobe   = st_q.strobe;
    assign out_addr = st_q.addr;
    assign out_data = st_q.wdata;

    assert_abort_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_hold) |=> (!busy && strobe && out_data == '1));

    assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    assert_strobe_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> ($past(busy) && !busy));

    assert_count_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (st_q.cnt <= CNT_LOAD));

endmodule

// File: rtl/wpc_top.sv
module wpc_top #(
    parameter int ADDR_W      = 9,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_open,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              wr_hold,
    output logic              busy_o,
    output logic              ready_o,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata
);

    logic busy;
    logic armed;
    logic write_ok;

    wpc_guard u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_open (frame_open),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .wr_hold    (wr_hold),
        .busy       (busy),
        .armed      (armed),
        .write_ok   (write_ok)
    );

    wpc_timer #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .PROG_CYCLES (PROG_CYCLES)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (write_ok),
        .wr_hold    (wr_hold),
        .start_addr (cmd_addr),
        .start_data (cmd_data),
        .busy       (busy),
        .strobe     (arr_we),
        .out_addr   (arr_addr),
        .out_data   (arr_wdata)
    );

    assign busy_o  = busy;
    assign ready_o = ~busy;

    assert_no_start_unarmed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !armed) |=> !busy);

    assert_no_start_on_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hold |=> !$rose(busy));

    assert_start_needs_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(cmd_valid) && $past(cmd_op) == 2'b01));

endmodule

// File: tb/wpc_top_test.sv
module wpc_top_test;

    localparam int AW = 9;
    localparam int DW = 16;
    localparam int PC = 20;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_open = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'b00;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_data = '0;
    logic          wr_hold = 1'b0;
    logic          busy_o, ready_o, arr_we;
    logic [AW-1:0] arr_addr;
    logic [DW-1:0] arr_wdata;

    int n_cmp = 0;
    int n_bad = 0;
    item_t exp_q[$];

    wpc_top #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PC)) uut (
        .clk(clk), .rst_n(rst_n), .frame_open(frame_open), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .wr_hold(wr_hold),
        .busy_o(busy_o), .ready_o(ready_o), .arr_we(arr_we),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pop expected commits as strobes appear
    always @(negedge clk) begin
        if (rst_n && arr_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected strobe", {arr_addr, arr_wdata}, 0);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                check(arr_addr == e.addr && arr_wdata == e.data, "R7/R8 commit",
                      {arr_addr, arr_wdata}, {e.addr, e.data});
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // four-cycle frame, cmd_valid in the last; optional one-cycle hold pulse
    task automatic send(input logic [1:0] op, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input int pulse_at);
        cmd_op = op; cmd_addr = a; cmd_data = d;
        for (int i = 0; i < 4; i++) begin
            frame_open = 1'b1;
            cmd_valid  = (i == 3);
            if (pulse_at >= 0) wr_hold = (i == pulse_at);
            @(negedge clk);
        end
        frame_open = 1'b0; cmd_valid = 1'b0;
        if (pulse_at >= 0) wr_hold = 1'b0;
    endtask

    task automatic write_ok(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
        int n = 0;
        exp_q.push_back({a, d});
        send(2'b01, a, d, -1);
        while (!ready_o && n < 1000) begin
            check(busy_o == 1'b1, "R6 busy flag", busy_o, 1);
            n++;
            @(negedge clk);
        end
        check(n == PC, req, n, PC);
        idle(2);
    endtask

    task automatic write_dropped(input logic [AW-1:0] a, input logic [DW-1:0] d,
                                 input int pulse_at, input string req);
        send(2'b01, a, d, pulse_at);
        check(ready_o == 1'b1, req, ready_o, 1);
        idle(PC + 3);
    endtask

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        check(ready_o == 1'b1 && busy_o == 1'b0 && arr_we == 1'b0, "R6 reset state",
              {ready_o, busy_o, arr_we}, 3'b100);

        // R1: writes blocked right after reset
        write_dropped(9'h005, 16'h1234, -1, "R1 write before arm");

        // R2/R6/R7: arm, then a full-length write to the top address
        send(2'b10, '0, '0, -1); idle(1);
        write_ok(9'h1FF, 16'hBEEF, "R2 R6 interval length");

        // R4: read keeps latch set
        send(2'b00, 9'h010, '0, -1); idle(1);
        write_ok(9'h010, 16'hA5A5, "R4 read keeps armed");

        // R3/R4: disarm, read, write dropped
        send(2'b11, '0, '0, -1); idle(1);
        send(2'b00, 9'h011, '0, -1); idle(1);
        write_dropped(9'h011, 16'h5555, -1, "R3 R4 write after disarm");

        // R9: arm under hold still arms
        wr_hold = 1'b1;
        send(2'b10, '0, '0, -1);
        wr_hold = 1'b0; idle(1);
        write_ok(9'h020, 16'h0F0F, "R9 arm under hold");

        // R5: hold early in the frame, and hold at the valid cycle
        write_dropped(9'h021, 16'h1111, 1, "R5 hold mid frame");
        write_dropped(9'h022, 16'h2222, 3, "R5 hold at last bit");
        write_ok(9'h023, 16'h3333, "R5 clean frame after hold");

        // R8: abort mid interval
        exp_q.push_back({9'h033, 16'hFFFF});
        send(2'b01, 9'h033, 16'h1357, -1);
        check(ready_o == 1'b0, "R8 busy before abort", ready_o, 0);
        idle(5);
        wr_hold = 1'b1;
        @(negedge clk);
        check(ready_o == 1'b1 && arr_we == 1'b1, "R8 abort returns ready",
              {ready_o, arr_we}, 2'b11);
        wr_hold = 1'b0;
        idle(2);

        // R10: commands during busy ignored
        exp_q.push_back({9'h040, 16'hC0DE});
        send(2'b01, 9'h040, 16'hC0DE, -1);
        send(2'b11, '0, '0, -1);
        send(2'b01, 9'h041, 16'hDEAD, -1);
        check(ready_o == 1'b0, "R10 still busy", ready_o, 0);
        idle(PC + 3);
        check(ready_o == 1'b1, "R10 interval done", ready_o, 1);
        write_ok(9'h042, 16'h7777, "R10 disarm ignored while busy");

        idle(4);
        check(exp_q.size() == 0, "R7 all commits seen", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule